// File: doc/BRIEF.md
# Even-Ratio Clock-Enable Prescaler with Fixed /32 Tick

This block turns a free-running reference clock into two streams of clock-enable pulses within the same clock domain. The first stream comes from a programmable even divider. It produces one single-cycle pulse every 2n reference cycles, where n is a 4-bit ratio held in a control register. When n is zero the divider is bypassed and the pulse stays high on every cycle. A run bit starts and stops this divider. The ratio can only be changed while the divider is stopped.

The second stream is a fixed divide-by-32 tick. Software can restart it from zero at any time by writing a one to a self-clearing strobe bit.

A narrow register port writes and reads both registers. The block has two kinds of reset. The asynchronous power-on reset clears everything. A synchronous soft reset input serves software and watchdog resets: it restarts both counters but leaves the control register exactly as it was.

Top module: `presc_top`

## Requirements
- R1: With ratio n in 1..15 and run set, `div_pulse` is high for exactly one cycle in every 2n cycles.
- R2: With ratio 0 and run set, `div_pulse` is high on every cycle.
- R3: With run clear, `div_pulse` stays low. When run is set, the first pulse falls in the 2n-th cycle of running, counting the first cycle after the write as cycle 1.
- R4: A control write made while run is 1 leaves the ratio unchanged. The run bit itself still takes the written value.
- R5: After power-on reset, the control register reads 0x00, the strobe register reads 0x00, and both outputs are low.
- R6: A soft reset pulse leaves the control register unchanged. It restarts the divider phase and clears the /32 counter.
- R7: Writing 1 to bit 0 at select 1 clears the /32 counter, so the next `tick32` comes 32 cycles later. Select 1 always reads 0x00.
- R8: `tick32` is a single-cycle pulse every 32 cycles.
- R9: The control register sits at select 0, with run in bit 7 and the ratio in bits 3:0. Bits 6:4 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous software/watchdog reset pulse |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 control, 1 clear strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| div_pulse | output | 1 | Programmable divider enable pulse |
| tick32 | output | 1 | Fixed divide-by-32 enable pulse |

## Verification
Two events can land in the same cycle: a clear-strobe write and the cycle in which `tick32` is already high. The bench provokes this by waiting until it sees the tick and then applying the strobe in that same cycle. It expects the tick to remain a single-cycle pulse, and the next tick to appear exactly 32 cycles after the strobe takes effect.

A second collision is a soft reset while the divider is running. Here the bench confirms two things. The control register still reads back its pre-reset value. The pulse phase restarts, so the next pulses follow the spacing expected from a fresh start.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int REG_W      = 8;
  localparam bit SEL_CTL    = 1'b0;
  localparam bit SEL_CLR    = 1'b1;
  localparam int RUN_BIT    = 7;
  localparam int CLR_BIT    = 0;
endpackage

// File: rtl/presc_regs.sv
module presc_regs
  import presc_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               sel,
  input  logic [REG_W-1:0]   wdata,
  output logic               run_q,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               run_d,
  output logic [RATIO_W-1:0] ratio_d,
  output logic               clr_pulse,
  output logic [REG_W-1:0]   rdata
);
  logic ctl_wr;
  logic unused_wbits;

  assign ctl_wr       = we && (sel == SEL_CTL);
  assign clr_pulse    = we && (sel == SEL_CLR) && wdata[CLR_BIT];
  assign unused_wbits = ^wdata;

  always_comb begin
    run_d   = run_q;
    ratio_d = ratio_q;
    if (ctl_wr) begin
      run_d = wdata[RUN_BIT];
      if (!run_q) ratio_d = wdata[RATIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ratio_q <= '0;
    end else begin
      run_q   <= run_d;
      ratio_q <= ratio_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_CTL) begin
      rdata[RATIO_W-1:0] = ratio_q;
      rdata[RUN_BIT]     = run_q;
    end
  end

  AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(ratio_q)); // R4
endmodule

// File: rtl/presc_div.sv
module presc_div #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               run_q,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic               run_d,
  input  logic [RATIO_W-1:0] ratio_d,
  output logic               pulse
);
  localparam int CW = RATIO_W + 1;

  logic [CW-1:0] cnt_q, cnt_d, reload;

  always_comb begin
    if (ratio_d == '0) reload = '0;
    else               reload = {ratio_d, 1'b0} - CW'(1);
  end

  always_comb begin
    if (soft_rst || !run_q || !run_d || (cnt_q == '0)) cnt_d = reload;
    else                                              cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse = run_q && (cnt_q == '0);

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && ratio_q != '0 && !soft_rst) |=> !pulse); // R1
  AST_BYPASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ratio_q == '0) |-> pulse); // R2
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_q) && ratio_q != '0) |-> !pulse); // R3
endmodule

// File: rtl/presc_fixdiv.sv
module presc_fixdiv #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr || cnt_q == CW'(DIV - 1)) cnt_d = '0;
    else                             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == CW'(DIV - 1));

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R7
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R8
endmodule

// File: rtl/presc_top.sv
module presc_top
  import presc_pkg::*;
#(
  parameter int RATIO_W = 4,
  parameter int FIX_DIV = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             div_pulse,
  output logic             tick32
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               run_q, run_d, clr_pulse;
  logic [RATIO_W-1:0] ratio_q, ratio_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  presc_regs #(.RATIO_W(RATIO_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .run_q(run_q), .ratio_q(ratio_q), .run_d(run_d), .ratio_d(ratio_d),
    .clr_pulse(clr_pulse), .rdata(reg_rdata)
  );

  presc_div #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .soft_rst(soft_rst),
    .run_q(run_q), .ratio_q(ratio_q), .run_d(run_d), .ratio_d(ratio_d),
    .pulse(div_pulse)
  );

  presc_fixdiv #(.DIV(FIX_DIV)) u_fix (
    .clk(clk), .rst_n(rst_int_n), .clr(clr_pulse || soft_rst), .tick(tick32)
  );

  AST_SOFT_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (soft_rst && !reg_we) |=> ($stable(run_q) && $stable(ratio_q))); // R6
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(run_q) |-> !div_pulse); // R3
endmodule

// File: tb/presc_top_tb.sv
module presc_top_tb;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst, reg_we, reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic       div_pulse, tick32;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  presc_top u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_pulse(div_pulse), .tick32(tick32)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00; reg_sel = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [7:0] d);
    reg_sel = sel; #0.5; d = reg_rdata; reg_sel = 1'b0; #0.1;
  endtask

  task automatic soft_pulse();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  // count mismatches of div_pulse against the 2n pattern starting at k=0
  task automatic div_window(input int n, input int len, input string req);
    int bad = 0, first_bad_act = 0, first_bad_exp = 0;
    for (int k = 0; k < len; k++) begin
      bit e = (n == 0) ? 1'b1 : ((k % (2*n)) == (2*n - 1));
      if (div_pulse !== e) begin
        if (bad == 0) begin first_bad_act = div_pulse; first_bad_exp = e; end
        bad++;
      end
      @(negedge clk);
    end
    check(req, bad == 0 ? 1 : first_bad_act, bad == 0 ? 1 : first_bad_exp);
  endtask

  task automatic t32_window(input int len, input string req);
    int bad = 0;
    for (int k = 0; k < len; k++) begin
      if (tick32 !== ((k % 32) == 31)) bad++;
      @(negedge clk);
    end
    check(req, bad, 0);
  endtask

  initial begin
    logic [7:0] r;
    bit seen;
    rst_n = 1'b0; soft_rst = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 reset state
    rd(1'b0, r); check("R5 ctl after reset", r, 0);
    rd(1'b1, r); check("R5 strobe after reset", r, 0);
    check("R5 div_pulse low", div_pulse, 0);
    check("R5 tick32 low", tick32, 0);

    // R9 unused bits read zero
    wr(1'b0, 8'h7A);
    rd(1'b0, r); check("R9 unused bits", r, 8'h0A);

    // R3 stopped: no pulse
    begin
      int cnt = 0;
      for (int k = 0; k < 40; k++) begin cnt += div_pulse; @(negedge clk); end
      check("R3 quiet while stopped", cnt, 0);
    end

    // R1/R2/R3 sweep all ratios
    for (int n = 0; n < 16; n++) begin
      wr(1'b0, 8'(n));
      wr(1'b0, 8'h80 | 8'(n));
      div_window(n, (n == 0) ? 16 : 8*n + 3, n == 0 ? "R2 bypass" : "R1/R3 spacing");
    end

    // R4 rejected ratio write while running
    wr(1'b0, 8'h05);
    wr(1'b0, 8'h85);
    wr(1'b0, 8'h83);
    rd(1'b0, r); check("R4 ratio kept while running", r, 8'h85);
    wr(1'b0, 8'h03);
    rd(1'b0, r); check("R4 run clears, ratio kept", r, 8'h05);
    wr(1'b0, 8'h03);
    rd(1'b0, r); check("R4 ratio accepted when stopped", r, 8'h03);

    // R6 soft reset while running
    wr(1'b0, 8'h05);
    wr(1'b0, 8'h85);
    repeat (7) @(negedge clk);
    soft_pulse();
    rd(1'b0, r); check("R6 ctl kept over soft reset", r, 8'h85);
    div_window(5, 43, "R6 phase restart");
    soft_pulse();
    t32_window(70, "R6 fix counter cleared");

    // R7 strobe and R8 period
    repeat (11) @(negedge clk);
    wr(1'b1, 8'h01);
    t32_window(70, "R7/R8 tick after strobe");
    rd(1'b1, r); check("R7 strobe reads zero", r, 0);

    // R7 strobe in the same cycle as a tick
    seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (tick32) seen = 1'b1; else @(negedge clk);
    end
    check("R7 tick found", seen, 1);
    wr(1'b1, 8'h01);
    check("R8 tick single cycle", tick32, 0);
    t32_window(66, "R7 strobe during tick");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule